// File: doc/BRIEF.md
# Configuration-space access decoder

This block sits beside a root-port bridge. It turns a host configuration request into a flat byte offset inside the memory-mapped configuration window, and into an absolute address. The request is given as a bus number, a device/function number and a register offset. The block also decides whether the request may be issued at all. A request is refused when it targets a non-zero device/function on the root bus, targets a downstream bus while the link is down, targets a bus beyond the programmed range, or arrives while the window is disabled. The result is registered and appears one cycle after the request, together with a one-cycle valid strobe.

A small word-addressed register interface configures the block. It holds a capability word, a control word with an enable and a 5-bit size field, a 64-bit window base written as two 32-bit halves, and a read-only view of the live link status. The size field is the number of the last usable bus, and it is also driven on a port.

Top module: `cfg_space_decoder`

## Requirements
- R1: An accepted request returns offset = (bus << 20) | (devfn << 12) | register offset, where the register offset is 12 bits. It also returns address = 64-bit base + offset.
- R2: On the root bus (bus 0), only devfn 0 is accepted. Any other devfn there is rejected.
- R3: A request to any bus other than the root bus is rejected while link status bit 0 (link up) is low. Link status bit 1 (PHY ready) alone does not permit it.
- R4: A request whose bus number is greater than the control size field is rejected. Bus equal to the size field is accepted.
- R5: While control bit 0 (enable) is low, every request is rejected.
- R6: A rejected read returns offset and address of all ones. A rejected write returns zero for both. In either case err=1 and ok=0.
- R7: rsp_vld is high exactly in the cycle after a cycle with req_vld high. Back-to-back requests give back-to-back responses. rsp_ok and rsp_err are low whenever rsp_vld is low.
- R8: Control register (word 1) resets to 0x000C0000, which is enable 0 and size 12. Only bit 0 and bits 20:16 are writable, and the other bits read 0. last_bus shows the size field.
- R9: Capability register (word 0) reads 0x1, which is present at bit 0. Writes to it have no effect.
- R10: Base low half is at word 2 and base high half at word 3. Both reset to 0, read back as written, and together form the 64-bit base used in R1, including the carry from the low half into the high half.
- R11: Word 4 reads the live link status in bits 1:0, with zeros above.
- R12: After reset, rsp_vld, rsp_ok and rsp_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| link_stat | input | 2 | Bit 0 link up, bit 1 PHY ready |
| req_vld | input | 1 | Request strobe |
| req_rd | input | 1 | 1 = read request, 0 = write |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function |
| req_off | input | 12 | Register byte offset |
| rsp_vld | output | 1 | Result valid, one cycle after request |
| rsp_ok | output | 1 | Request accepted |
| rsp_err | output | 1 | Request rejected |
| rsp_offset | output | 28 | Window byte offset |
| rsp_addr | output | 64 | Absolute address |
| last_bus | output | 8 | Last usable bus number |

## Verification
Requests are issued at the root bus with devfn 0 and non-zero devfn, which separates the root-port rule from the composition. Downstream buses are tried under all link-status codes, which shows that only the link-up bit admits them. Bus numbers one below, equal to and one above the size field are tried at three different size settings, and these expose off-by-one range errors. A base whose low half is near overflow exposes a missing carry. Rejected reads and rejected writes are sent back to back, which separates the two fill values and checks the one-cycle strobe.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  localparam int REG_AW      = 3;
  localparam int SIZE_W      = 5;
  localparam int SIZE_LSB    = 16;
  localparam int EN_BIT      = 0;
  localparam logic [SIZE_W-1:0] SIZE_RST = 5'd12;

  localparam logic [REG_AW-1:0] IDX_CAP     = 3'd0;
  localparam logic [REG_AW-1:0] IDX_CTRL    = 3'd1;
  localparam logic [REG_AW-1:0] IDX_BASE_LO = 3'd2;
  localparam logic [REG_AW-1:0] IDX_BASE_HI = 3'd3;
  localparam logic [REG_AW-1:0] IDX_LINK    = 3'd4;
endpackage

// File: rtl/cfgdec_regs.sv
module cfgdec_regs
  import cfgdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [1:0]        link_stat,
  output logic              win_en,
  output logic [SIZE_W-1:0] win_size,
  output logic [63:0]       win_base
);
  logic              en_q, en_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic [31:0]       lo_q, lo_d, hi_q, hi_d;

  // next-state
  always_comb begin
    en_d   = en_q;
    size_d = size_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    if (we) begin
      unique case (addr)
        IDX_CTRL: begin
          en_d   = wdata[EN_BIT];
          size_d = wdata[SIZE_LSB +: SIZE_W];
        end
        IDX_BASE_LO: lo_d = wdata;
        IDX_BASE_HI: hi_d = wdata;
        default: ;
      endcase
    end
  end

  // state (R8 / R10 reset values)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      size_q <= SIZE_RST;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      en_q   <= en_d;
      size_q <= size_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end

  // read mux (R9, R11)
  always_comb begin
    rdata = '0;
    unique case (addr)
      IDX_CAP:     rdata[0] = 1'b1;
      IDX_CTRL: begin
        rdata[EN_BIT]              = en_q;
        rdata[SIZE_LSB +: SIZE_W]  = size_q;
      end
      IDX_BASE_LO: rdata = lo_q;
      IDX_BASE_HI: rdata = hi_q;
      IDX_LINK:    rdata[1:0] = link_stat;
      default:     rdata = '0;
    endcase
  end

  assign win_en   = en_q;
  assign win_size = size_q;
  assign win_base = {hi_q, lo_q};
endmodule

// File: rtl/cfgdec_xlate.sv
module cfgdec_xlate #(
  parameter int BUS_W    = 8,
  parameter int DEVFN_W  = 8,
  parameter int REG_W    = 12,
  parameter int SIZE_W   = 5,
  parameter int ROOT_BUS = 0,
  localparam int OFF_W   = BUS_W + DEVFN_W + REG_W
) (
  input  logic               en,
  input  logic [SIZE_W-1:0]  size,
  input  logic [63:0]        base,
  input  logic               link_up,
  input  logic [BUS_W-1:0]   bus,
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [REG_W-1:0]   off,
  input  logic               rd,
  output logic               ok,
  output logic [OFF_W-1:0]   offset,
  output logic [63:0]        addr
);
  localparam logic [BUS_W-1:0] ROOT = BUS_W'(ROOT_BUS);

  logic [OFF_W-1:0] raw_off;
  logic [63:0]      raw_addr;
  logic             on_root, bad_root, bad_link, bad_range;

  always_comb begin
    raw_off   = {bus, devfn, off};
    raw_addr  = base + 64'(raw_off);
    on_root   = (bus == ROOT);
    bad_root  = on_root && (devfn != '0);
    bad_link  = !on_root && !link_up;
    bad_range = (bus > BUS_W'(size));
    ok        = en && !bad_root && !bad_link && !bad_range;
    if (ok) begin
      offset = raw_off;
      addr   = raw_addr;
    end else if (rd) begin
      offset = '1;
      addr   = '1;
    end else begin
      offset = '0;
      addr   = '0;
    end
  end
endmodule

// File: rtl/cfg_space_decoder.sv
module cfg_space_decoder
  import cfgdec_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int DEVFN_W  = 8,
  parameter int REG_W    = 12,
  parameter int ROOT_BUS = 0,
  localparam int OFF_W   = BUS_W + DEVFN_W + REG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [1:0]         link_stat,
  input  logic               req_vld,
  input  logic               req_rd,
  input  logic [BUS_W-1:0]   req_bus,
  input  logic [DEVFN_W-1:0] req_devfn,
  input  logic [REG_W-1:0]   req_off,
  output logic               rsp_vld,
  output logic               rsp_ok,
  output logic               rsp_err,
  output logic [OFF_W-1:0]   rsp_offset,
  output logic [63:0]        rsp_addr,
  output logic [BUS_W-1:0]   last_bus
);
  logic              win_en;
  logic [SIZE_W-1:0] win_size;
  logic [63:0]       win_base;
  logic              x_ok;
  logic [OFF_W-1:0]  x_off;
  logic [63:0]       x_addr;

  cfgdec_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .link_stat(link_stat),
    .win_en(win_en), .win_size(win_size), .win_base(win_base)
  );

  cfgdec_xlate #(
    .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .REG_W(REG_W),
    .SIZE_W(SIZE_W), .ROOT_BUS(ROOT_BUS)
  ) u_xlate (
    .en(win_en), .size(win_size), .base(win_base), .link_up(link_stat[0]),
    .bus(req_bus), .devfn(req_devfn), .off(req_off), .rd(req_rd),
    .ok(x_ok), .offset(x_off), .addr(x_addr)
  );

  // result stage: next-state
  logic             vld_d, ok_d, err_d;
  logic [OFF_W-1:0] off_d;
  logic [63:0]      addr_d;
  logic             ld;

  always_comb begin
    ld     = req_vld;
    vld_d  = req_vld;
    ok_d   = req_vld && x_ok;
    err_d  = req_vld && !x_ok;
    off_d  = rsp_offset;
    addr_d = rsp_addr;
    if (ld) begin
      off_d  = x_off;
      addr_d = x_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld    <= 1'b0;
      rsp_ok     <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_offset <= '0;
      rsp_addr   <= '0;
    end else begin
      rsp_vld    <= vld_d;
      rsp_ok     <= ok_d;
      rsp_err    <= err_d;
      rsp_offset <= off_d;
      rsp_addr   <= addr_d;
    end
  end

  assign last_bus = BUS_W'(win_size);

  // assertions
  a_r7_vld_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);
  a_r7_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld);
  a_r7_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_vld |-> (!rsp_ok && !rsp_err));
  a_r6_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> $countones({rsp_ok, rsp_err}) == 1);
  a_r2_root_devfn: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_bus == BUS_W'(ROOT_BUS) && req_devfn != '0) |=> rsp_err);
  a_r3_link_down: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_bus != BUS_W'(ROOT_BUS) && !link_stat[0]) |=> rsp_err);
  a_r4_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_bus > last_bus) |=> rsp_err);
  a_r5_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !win_en) |=> rsp_err);
  a_r6_rd_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_rd) |=> (rsp_err |-> (&rsp_offset)));
endmodule

// File: tb/sim_cfg_space_decoder.sv
module sim_cfg_space_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [1:0]  link_stat;
  logic        req_vld, req_rd;
  logic [7:0]  req_bus, req_devfn;
  logic [11:0] req_off;
  logic        rsp_vld, rsp_ok, rsp_err;
  logic [27:0] rsp_offset;
  logic [63:0] rsp_addr;
  logic [7:0]  last_bus;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cfg_space_decoder u0 (.*);

  typedef struct {
    logic        ok;
    logic [27:0] off;
    logic [63:0] addr;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  // bench-side model state
  logic        m_en;
  logic [4:0]  m_size;
  logic [63:0] m_base;

  function automatic exp_t predict(logic [7:0] b, logic [7:0] d,
                                   logic [11:0] o, logic rd, string tag);
    exp_t e;
    logic good;
    good = m_en && !(b == 8'd0 && d != 8'd0) && !(b != 8'd0 && !link_stat[0])
           && (b <= {3'b0, m_size});
    e.ok  = good;
    e.tag = tag;
    if (good) begin
      e.off  = {b, d, o};
      e.addr = m_base + {36'd0, b, d, o};
    end else begin
      e.off  = rd ? 28'hFFFFFFF : 28'h0;
      e.addr = rd ? '1 : '0;
    end
    return e;
  endfunction

  task automatic check(bit cond, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b, logic [7:0] d, logic [11:0] o,
                      logic rd, string tag);
    @(negedge clk);
    req_vld = 1'b1; req_bus = b; req_devfn = d; req_off = o; req_rd = rd;
    sbq.push_back(predict(b, d, o, rd, tag));
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      req_vld = 1'b0;
    end
  endtask

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    req_vld = 1'b0;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 3'd1) begin m_en = d[0]; m_size = d[20:16]; end
    if (a == 3'd2) m_base[31:0]  = d;
    if (a == 3'd3) m_base[63:32] = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_chk(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
  endtask

  // monitor: pops expectations as responses appear
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_vld) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R7 unexpected rsp_vld", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(rsp_ok == e.ok && rsp_err == !e.ok, {e.tag, " verdict"},
                64'({rsp_ok, rsp_err}), 64'({e.ok, !e.ok}));
          check(rsp_offset == e.off, {e.tag, " offset"}, 64'(rsp_offset), 64'(e.off));
          check(rsp_addr == e.addr, {e.tag, " addr"}, rsp_addr, e.addr);
        end
      end else if (rst_n) begin
        check(!rsp_ok && !rsp_err, "R7 flags low when idle",
              64'({rsp_ok, rsp_err}), 64'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    link_stat = 2'b00; req_vld = 1'b0; req_rd = 1'b0;
    req_bus = '0; req_devfn = '0; req_off = '0;
    m_en = 1'b0; m_size = 5'd12; m_base = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 / R8 / R9 / R10 / R11 reset state
    @(negedge clk);
    check(!rsp_vld && !rsp_ok && !rsp_err, "R12 reset outputs",
          64'({rsp_vld, rsp_ok, rsp_err}), 64'd0);
    check(last_bus == 8'd12, "R8 reset last_bus", 64'(last_bus), 64'd12);
    reg_chk(3'd1, 32'h000C0000, "R8 ctrl reset");
    reg_chk(3'd0, 32'h1, "R9 cap reads present");
    reg_chk(3'd2, 32'h0, "R10 base lo reset");
    reg_chk(3'd3, 32'h0, "R10 base hi reset");
    reg_chk(3'd4, 32'h0, "R11 link status 00");

    // R5: disabled window rejects even a legal root request
    link_stat = 2'b01;
    send(8'd0, 8'd0, 12'h010, 1'b1, "R5 disabled read");
    send(8'd1, 8'd0, 12'h010, 1'b0, "R5 disabled write");
    idle(2);

    // R8: write mask
    reg_wr(3'd1, 32'hABCD1235);
    reg_chk(3'd1, 32'h000D0001, "R8 ctrl write mask");
    check(last_bus == 8'd13, "R8 last_bus follows size", 64'(last_bus), 64'd13);
    reg_wr(3'd1, 32'h000C0001);

    // R9: capability write ignored
    reg_wr(3'd0, 32'h0);
    reg_chk(3'd0, 32'h1, "R9 cap write ignored");

    // R10: base halves
    reg_wr(3'd2, 32'h1000_0000);
    reg_wr(3'd3, 32'h0000_0004);
    reg_chk(3'd2, 32'h1000_0000, "R10 base lo readback");
    reg_chk(3'd3, 32'h0000_0004, "R10 base hi readback");

    // R1 / R2 root bus, link down
    @(negedge clk); link_stat = 2'b00;
    send(8'd0, 8'd0, 12'hABC, 1'b1, "R1 root devfn0 link down");
    send(8'd0, 8'd8, 12'h004, 1'b1, "R2 root devfn8 read");
    send(8'd0, 8'd1, 12'h004, 1'b0, "R2 root devfn1 write");
    // R3 downstream under link codes
    send(8'd1, 8'd0, 12'h000, 1'b1, "R3 bus1 link 00");
    idle(1);
    link_stat = 2'b10;
    reg_chk(3'd4, 32'h2, "R11 link status 10");
    send(8'd2, 8'd0, 12'h000, 1'b1, "R3 bus2 phy-ready only");
    idle(1);
    link_stat = 2'b01;
    send(8'd1, 8'h1F, 12'hFFC, 1'b1, "R1 bus1 devfn1F link up");
    send(8'd5, 8'hFF, 12'h100, 1'b0, "R1 bus5 write link up");
    // R4 range at size 12
    send(8'd11, 8'd3, 12'h0, 1'b1, "R4 bus11 size12");
    send(8'd12, 8'd3, 12'h0, 1'b1, "R4 bus12 size12");
    send(8'd13, 8'd3, 12'h0, 1'b1, "R4 bus13 size12 read");
    send(8'd13, 8'd3, 12'h0, 1'b0, "R6 bus13 rejected write");
    idle(2);
    link_stat = 2'b11;
    reg_chk(3'd4, 32'h3, "R11 link status 11");

    // R4 at size 31 and size 0
    reg_wr(3'd1, 32'h001F0001);
    send(8'd31, 8'd0, 12'h008, 1'b1, "R4 bus31 size31");
    send(8'd32, 8'd0, 12'h008, 1'b1, "R4 bus32 size31");
    send(8'd255, 8'd0, 12'h008, 1'b0, "R4 bus255 size31 write");
    idle(1);
    reg_wr(3'd1, 32'h00000001);
    send(8'd0, 8'd0, 12'h040, 1'b1, "R4 bus0 size0");
    send(8'd1, 8'd0, 12'h040, 1'b1, "R4 bus1 size0");
    idle(1);

    // R10 carry from low half into high half
    reg_wr(3'd1, 32'h00100001);
    reg_wr(3'd2, 32'hFFFF_F000);
    reg_wr(3'd3, 32'h0000_00FF);
    send(8'd3, 8'h10, 12'h234, 1'b1, "R10 carry into base hi");
    idle(1);

    // R5 disable again after use
    reg_wr(3'd1, 32'h00100000);
    send(8'd0, 8'd0, 12'h0, 1'b1, "R5 disabled again");
    idle(3);

    check(sbq.size() == 0, "R7 all responses seen", 64'(sbq.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule